// File: doc/BRIEF.md
# Vectored Interrupt Controller Core

This block collects a fixed set of interrupt lines for one machine-mode hart. It keeps four byte-wide registers per line: a pending flag, an enable flag, a trigger attribute and a priority level. Every cycle it picks the best pending line and presents it to the hart as a registered request with that line's identifier and level. Each line's attribute chooses level or edge sensing and the active polarity. Only the upper `CTL_BITS` bits of each level byte are stored. A single threshold register keeps low-level interrupts away from the hart.

Software reaches the registers through a word-addressed write/read port with byte lanes. Word `i` belongs to line `i`, and word `N_IRQ` holds the threshold. After the hart takes an edge-triggered interrupt, it returns a claim pulse carrying the identifier. The claim clears that line's latched pending flag.

Top module: `vic_core`

## Requirements
- R1: After reset, every line has pending 0, enable 0 and attribute 0, and its level byte reads with only the unimplemented bits set. The threshold is 0, `irq_req` is 0 and `irq_id`/`irq_lvl` are 0.
- R2: Word `i < N_IRQ` reads `{level[31:24], 6'b0, attr[17:16], 7'b0, enable[8], 7'b0, pending[0]}`. In the attribute field, bit 16 selects edge (1) or level (0) and bit 17 selects active-low/falling (1) or active-high/rising (0). Word `N_IRQ` holds the threshold in bits 7:0, and any other word reads 0. Each byte lane writes only its own field, and all four lanes may be written at once.
- R3: Only the top `CTL_BITS` bits of a level byte are stored. The lower bits always read as 1, and comparisons use the filled 8-bit value.
- R4: In level mode, pending equals the synchronised input XOR the polarity bit. Software writes to the pending byte have no effect.
- R5: In edge mode, an active edge of the synchronised input sets pending, and pending stays set after the input returns. Software may set or clear pending.
- R6: A claim pulse whose identifier matches an edge-mode line clears that line's pending flag. An active edge in the same cycle takes precedence.
- R7: A pending line whose enable is 0 is never selected.
- R8: A line is presented only when its filled level is strictly greater than the threshold.
- R9: Among eligible lines, the highest filled level wins. On equal levels, the higher identifier wins.
- R10: The outputs are registered and change one cycle after a register write. A level input reaches the outputs three clock edges after it changes, and an edge input reaches them four clock edges after its edge.
- R11: While `irq_req` is 0, `irq_id` and `irq_lvl` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_IRQ | Raw interrupt lines |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | $clog2(N_IRQ+1) | Word index |
| bus_be | input | 4 | Byte lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| claim | input | 1 | Claim pulse from the hart |
| claim_id | input | IDW | Identifier being claimed |
| irq_req | output | 1 | Interrupt request to the hart |
| irq_id | output | IDW | Identifier of the selected line |
| irq_lvl | output | 8 | Filled level of the selected line |

## Verification
The selector is driven with several patterns, and each one separates different faults.

- A single active-high level line, then the same line disabled, separates enable masking from raw pending.
- A rising edge, then a falling edge, each followed by a claim, shows latching against following, and polarity against trigger type.
- Two lines at equal level separate the identifier tie-break from a wrong order.
- A higher level beating both of them, combined with threshold values equal to and just below the winner's level, exposes an off-by-one in the threshold compare.
- An active-low level line, and byte writes to a single lane, show that polarity and lane isolation work apart from the arbitration.

// File: rtl/vic_pkg.sv
package vic_pkg;

  typedef struct packed {
    logic pol;      // 1: active-low / falling edge
    logic edge_md;  // 1: edge-sensitive
  } vic_attr_t;

  // Keep the top 'bits' bits of v and force the rest to 1
  function automatic logic [7:0] ctl_fill(input logic [7:0] v, input int bits);
    logic [7:0] keep;
    keep = 8'hFF << (8 - bits);
    return (v & keep) | ~keep;
  endfunction

endpackage

// File: rtl/vic_in_sync.sv
module vic_in_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_raw,
  input  logic pol,
  output logic act,
  output logic edge_hit
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= irq_raw;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign act      = s2_q ^ pol;
  assign edge_hit = act & ~(prev_q ^ pol);
endmodule

// File: rtl/vic_slot.sv
module vic_slot
  import vic_pkg::*;
#(
  parameter int CTL_BITS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic        wd_pend,
  input  logic        wd_en,
  input  logic [1:0]  wd_attr,
  input  logic [7:0]  wd_ctl,
  input  logic        claim_hit,
  input  logic        act,
  input  logic        edge_hit,
  output logic        pend,
  output logic        en,
  output vic_attr_t   attr,
  output logic [7:0]  ctl_eff,
  output logic [31:0] rd_word
);
  localparam logic [7:0] CTL_RST = ctl_fill(8'h00, CTL_BITS);

  logic      en_q, en_d;
  vic_attr_t attr_q, attr_d;
  logic [7:0] ctl_q, ctl_d;
  logic      pe_q, pe_d;

  always_comb begin
    en_d   = en_q;
    attr_d = attr_q;
    ctl_d  = ctl_q;
    pe_d   = pe_q;
    if (wr_en && be[1]) en_d   = wd_en;
    if (wr_en && be[2]) attr_d = vic_attr_t'(wd_attr);
    if (wr_en && be[3]) ctl_d  = ctl_fill(wd_ctl, CTL_BITS);
    if (!attr_q.edge_md)        pe_d = 1'b0;
    else if (edge_hit)          pe_d = 1'b1;
    else if (claim_hit)         pe_d = 1'b0;
    else if (wr_en && be[0])    pe_d = wd_pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      attr_q <= '0;
      ctl_q  <= CTL_RST;
      pe_q   <= 1'b0;
    end else begin
      en_q   <= en_d;
      attr_q <= attr_d;
      ctl_q  <= ctl_d;
      pe_q   <= pe_d;
    end
  end

  assign pend    = attr_q.edge_md ? pe_q : act;
  assign en      = en_q;
  assign attr    = attr_q;
  assign ctl_eff = ctl_q;
  assign rd_word = {ctl_q, 6'b0, attr_q, 7'b0, en_q, 7'b0, pend};
endmodule

// File: rtl/vic_pick.sv
module vic_pick #(
  parameter int N_IRQ = 4,
  parameter int IDW   = 2
) (
  input  logic [N_IRQ-1:0]      cand,
  input  logic [N_IRQ-1:0][7:0] lvl,
  input  logic [7:0]            thresh,
  output logic                  hit,
  output logic [IDW-1:0]        id,
  output logic [7:0]            best
);
  always_comb begin
    hit  = 1'b0;
    id   = '0;
    best = 8'h00;
    for (int i = 0; i < N_IRQ; i++) begin
      if (cand[i] && (lvl[i] > thresh) && (!hit || lvl[i] >= best)) begin
        hit  = 1'b1;
        id   = IDW'(i);
        best = lvl[i];
      end
    end
  end
endmodule

// File: rtl/vic_core.sv
module vic_core
  import vic_pkg::*;
#(
  parameter int N_IRQ    = 4,
  parameter int CTL_BITS = 3,
  localparam int IDW     = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
  localparam int AW      = $clog2(N_IRQ + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [3:0]       bus_be,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             claim,
  input  logic [IDW-1:0]   claim_id,
  output logic             irq_req,
  output logic [IDW-1:0]   irq_id,
  output logic [7:0]       irq_lvl
);
  localparam logic [AW-1:0] THR_ADDR = AW'(N_IRQ);

  logic [N_IRQ-1:0]       pend_vec, en_vec, cand_vec;
  logic [N_IRQ-1:0]       edge_mode_vec, edge_hit_vec, act_vec;
  logic [N_IRQ-1:0][7:0]  ctl_vec;
  logic [N_IRQ-1:0][31:0] words;
  logic [7:0]             thr_q, thr_d;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    vic_attr_t a;
    logic      pol_s;

    assign pol_s = a.pol;

    vic_in_sync u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_raw  (irq_in[i]),
      .pol      (pol_s),
      .act      (act_vec[i]),
      .edge_hit (edge_hit_vec[i])
    );

    vic_slot #(.CTL_BITS(CTL_BITS)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (bus_we && (bus_addr == AW'(i))),
      .be        (bus_be),
      .wd_pend   (bus_wdata[0]),
      .wd_en     (bus_wdata[8]),
      .wd_attr   (bus_wdata[17:16]),
      .wd_ctl    (bus_wdata[31:24]),
      .claim_hit (claim && (claim_id == IDW'(i))),
      .act       (act_vec[i]),
      .edge_hit  (edge_hit_vec[i]),
      .pend      (pend_vec[i]),
      .en        (en_vec[i]),
      .attr      (a),
      .ctl_eff   (ctl_vec[i]),
      .rd_word   (words[i])
    );

    assign edge_mode_vec[i] = a.edge_md;
  end

  assign cand_vec = pend_vec & en_vec;

  // Threshold register
  always_comb begin
    thr_d = thr_q;
    if (bus_we && (bus_addr == THR_ADDR) && bus_be[0]) thr_d = bus_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= 8'h00;
    else        thr_q <= thr_d;
  end

  // Read mux
  always_comb begin
    bus_rdata = 32'h0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (bus_addr == AW'(i)) bus_rdata = words[i];
    end
    if (bus_addr == THR_ADDR) bus_rdata = {24'h0, thr_q};
  end

  // Selection and registered outputs
  logic           sel_hit;
  logic [IDW-1:0] sel_id;
  logic [7:0]     sel_lvl;

  vic_pick #(.N_IRQ(N_IRQ), .IDW(IDW)) u_pick (
    .cand   (cand_vec),
    .lvl    (ctl_vec),
    .thresh (thr_q),
    .hit    (sel_hit),
    .id     (sel_id),
    .best   (sel_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_id  <= '0;
      irq_lvl <= 8'h00;
    end else begin
      irq_req <= sel_hit;
      irq_id  <= sel_id;
      irq_lvl <= sel_lvl;
    end
  end
endmodule

// File: rtl/vic_core_chk.sv
module vic_core_chk #(
  parameter int N_IRQ    = 4,
  parameter int IDW      = 2,
  parameter int CTL_BITS = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  irq_req,
  input logic [IDW-1:0]        irq_id,
  input logic [7:0]            irq_lvl,
  input logic [N_IRQ-1:0]      cand_vec,
  input logic [N_IRQ-1:0]      pend_vec,
  input logic [N_IRQ-1:0]      edge_mode_vec,
  input logic [N_IRQ-1:0]      edge_hit_vec,
  input logic [7:0]            thr_q,
  input logic                  claim,
  input logic [IDW-1:0]        claim_id
);
  localparam logic [7:0] LOW_ONES = ~(8'hFF << (8 - CTL_BITS));

  // R7
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((($past(cand_vec) >> irq_id) & 1) != 0));

  // R8
  above_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_lvl > $past(thr_q)));

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_id == '0 && irq_lvl == 8'h00));

  // R3
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((irq_lvl & LOW_ONES) == LOW_ONES));

  // R6
  claim_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && edge_mode_vec[claim_id] && !edge_hit_vec[claim_id])
      |=> !pend_vec[$past(claim_id)]);
endmodule

bind vic_core vic_core_chk #(.N_IRQ(N_IRQ), .IDW(IDW), .CTL_BITS(CTL_BITS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .irq_req       (irq_req),
  .irq_id        (irq_id),
  .irq_lvl       (irq_lvl),
  .cand_vec      (cand_vec),
  .pend_vec      (pend_vec),
  .edge_mode_vec (edge_mode_vec),
  .edge_hit_vec  (edge_hit_vec),
  .thr_q         (thr_q),
  .claim         (claim),
  .claim_id      (claim_id)
);

// File: tb/sim_vic_core.sv
`timescale 1ns/1ps
module sim_vic_core;
  localparam int N   = 4;
  localparam int CB  = 3;
  localparam int IDW = 2;
  localparam int AW  = 3;
  localparam logic [7:0] KEEP = 8'hFF << (8 - CB);

  logic clk, rst_n;
  logic [N-1:0] irq_in;
  logic bus_we;
  logic [AW-1:0] bus_addr;
  logic [3:0] bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic claim;
  logic [IDW-1:0] claim_id;
  logic irq_req;
  logic [IDW-1:0] irq_id;
  logic [7:0] irq_lvl;

  vic_core #(.N_IRQ(N), .CTL_BITS(CB)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .claim(claim), .claim_id(claim_id),
    .irq_req(irq_req), .irq_id(irq_id), .irq_lvl(irq_lvl)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [N-1:0] m_s1, m_s2, m_prev, m_en, m_pe;
  logic [1:0]   m_attr [N];
  logic [7:0]   m_ctl [N];
  logic [7:0]   m_thr, m_lvl;
  logic         m_req;
  int           m_id;

  function automatic logic m_pend(int i);
    return m_attr[i][0] ? m_pe[i] : (m_s2[i] ^ m_attr[i][1]);
  endfunction

  function automatic logic [31:0] m_rd(int a);
    if (a < N) return {m_ctl[a], 6'b0, m_attr[a], 7'b0, m_en[a], 7'b0, m_pend(a)};
    if (a == N) return {24'h0, m_thr};
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_en = '0; m_pe = '0;
      m_thr = 8'h00; m_req = 0; m_id = 0; m_lvl = 8'h00;
      for (int i = 0; i < N; i++) begin m_attr[i] = 2'b00; m_ctl[i] = ~KEEP; end
    end else begin
      bit h; int bid; logic [7:0] bl;
      h = 0; bid = 0; bl = 8'h00;
      for (int i = 0; i < N; i++)
        if (m_pend(i) && m_en[i] && m_ctl[i] > m_thr && (!h || m_ctl[i] >= bl)) begin
          h = 1; bid = i; bl = m_ctl[i];
        end
      m_req = h; m_id = bid; m_lvl = bl;
      for (int i = 0; i < N; i++) begin
        logic a_now, a_old, wr;
        a_now = m_s2[i] ^ m_attr[i][1];
        a_old = m_prev[i] ^ m_attr[i][1];
        wr = bus_we && (int'(bus_addr) == i);
        if (!m_attr[i][0]) m_pe[i] = 0;
        else if (a_now && !a_old) m_pe[i] = 1;
        else if (claim && int'(claim_id) == i) m_pe[i] = 0;
        else if (wr && bus_be[0]) m_pe[i] = bus_wdata[0];
        if (wr && bus_be[1]) m_en[i] = bus_wdata[8];
        if (wr && bus_be[2]) m_attr[i] = bus_wdata[17:16];
        if (wr && bus_be[3]) m_ctl[i] = (bus_wdata[31:24] & KEEP) | ~KEEP;
      end
      if (bus_we && int'(bus_addr) == N && bus_be[0]) m_thr = bus_wdata[7:0];
      m_prev = m_s2; m_s2 = m_s1; m_s1 = irq_in;
    end
  end

  // Per-cycle comparison against the model (R10, R2)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R10 req", 32'(irq_req), 32'(m_req));
      check("R10 id", 32'(irq_id), 32'(m_id));
      check("R10 lvl", 32'(irq_lvl), 32'(m_lvl));
      check("R2 rdata", bus_rdata, m_rd(int'(bus_addr)));
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(int a, logic [3:0] be, logic [31:0] d);
    @(negedge clk); #1;
    bus_we = 1; bus_addr = AW'(a); bus_be = be; bus_wdata = d;
    @(negedge clk); #1;
    bus_we = 0; bus_be = 4'h0;
  endtask

  task automatic clm(int id);
    @(negedge clk); #1;
    claim = 1; claim_id = IDW'(id);
    @(negedge clk); #1;
    claim = 0;
  endtask

  task automatic rd_chk(int a, logic [31:0] exp, string tag);
    @(negedge clk); #1;
    bus_addr = AW'(a); #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic out_chk(logic r, int id, logic [7:0] l, string tag);
    check(tag, 32'(irq_req), 32'(r));
    if (r) begin
      check(tag, 32'(irq_id), 32'(id));
      check(tag, 32'(irq_lvl), 32'(l));
    end
  endtask

  task automatic set_in(int k, logic v);
    @(negedge clk); #1;
    irq_in[k] = v;
  endtask

  initial begin
    #(20ns * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; irq_in = '0; bus_we = 0; bus_addr = '0; bus_be = 4'h0;
    bus_wdata = 32'h0; claim = 0; claim_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(1);
    // R1 reset state, R11 idle outputs
    rd_chk(0, 32'h1F00_0000, "R1 word0");
    rd_chk(4, 32'h0, "R1 thresh");
    check("R1 req", 32'(irq_req), 0);
    check("R11 id", 32'(irq_id), 0);
    check("R11 lvl", 32'(irq_lvl), 0);

    // R3 level byte fill, R2 full-word write
    wr(0, 4'hF, 32'h4000_0100);
    rd_chk(0, 32'h5F00_0100, "R3 word0");

    // R4 active-high level, three edges to the output
    set_in(0, 1);
    idle(3);
    out_chk(1, 0, 8'h5F, "R4 level high");
    rd_chk(0, 32'h5F00_0101, "R4 pend read");

    // R7 disable masks
    wr(0, 4'b0010, 32'h0);
    idle(1);
    check("R7 masked", 32'(irq_req), 0);
    // R4 software write to pending ignored in level mode
    set_in(0, 0);
    idle(3);
    wr(0, 4'b0001, 32'h1);
    rd_chk(0, 32'h5F00_0000, "R4 pend write ignored");
    set_in(0, 1);
    idle(3);

    // R5 rising edge latches
    wr(1, 4'hF, 32'hA001_0100);
    set_in(1, 1); idle(1); irq_in[1] = 0;
    idle(3);
    out_chk(1, 1, 8'hBF, "R5 rising latched");
    // R6 claim clears
    clm(1); idle(1);
    check("R6 claim", 32'(irq_req), 0);
    // R5 software set in edge mode
    wr(1, 4'b0001, 32'h1); idle(1);
    out_chk(1, 1, 8'hBF, "R5 sw set");
    clm(1); idle(1);

    // R5 falling edge on line 2
    set_in(2, 1); idle(3);
    wr(2, 4'hF, 32'hA003_0100); idle(2);
    check("R5 no spurious", 32'(irq_req), 0);
    set_in(2, 0); idle(4);
    out_chk(1, 2, 8'hBF, "R5 falling latched");

    // R9 tie goes to higher id
    wr(1, 4'b0001, 32'h1); idle(1);
    out_chk(1, 2, 8'hBF, "R9 tie");
    clm(2); idle(1);
    out_chk(1, 1, 8'hBF, "R9 after claim");
    // R9 higher level wins
    wr(0, 4'b1010, 32'hE000_0100); idle(1);
    out_chk(1, 0, 8'hFF, "R9 higher level");

    // R8 threshold strict compare
    wr(4, 4'b0001, 32'hFF); idle(1);
    check("R8 equal blocked", 32'(irq_req), 0);
    wr(4, 4'b0001, 32'hBF); idle(1);
    out_chk(1, 0, 8'hFF, "R8 above");
    wr(0, 4'b1000, 32'h4000_0000); idle(1);
    check("R8 equal to thr", 32'(irq_req), 0);
    wr(4, 4'b0001, 32'hBE); idle(1);
    out_chk(1, 1, 8'hBF, "R8 just above");

    // R4 active-low level on line 3
    wr(3, 4'hF, 32'hE002_0100); idle(1);
    out_chk(1, 3, 8'hFF, "R4 active low");
    set_in(3, 1); idle(3);
    out_chk(1, 1, 8'hBF, "R4 active low release");

    // R2 single lane write leaves other lanes
    wr(3, 4'b0100, 32'h0);
    rd_chk(3, 32'hFF00_0101, "R2 lane isolation");
    rd_chk(4, 32'h0000_00BE, "R2 thresh read");
    rd_chk(7, 32'h0, "R2 unmapped");

    idle(2);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule